// File: doc/BRIEF.md
# Jump-Target Trace Buffer

This block is a debug capture unit that sits beside a 32-bit processor and watches its program-counter stream. Each cycle in which the processor presents a valid PC, the block compares that PC with the one it saw last. It records the new value only when the step is not the usual four-byte increment. The history therefore holds the targets of taken branches, jumps and exception entries, not every fetched address.

Captured targets go into a 32-entry circular history. When the history is full, each new capture overwrites the oldest entry. A debugger reads the history through a combinational indexed port: logical index 0 is the oldest entry and index 31 is the most recent. A freeze input stops capture so that the contents stay put while they are read out. The PC tracking goes on while frozen, so releasing the freeze does not produce a false capture.

Top module: `branch_trace_buf`

## Requirements
- R1: After reset every one of the 32 entries reads 0xFFFFFFFF at every read index, the write pointer is 0 and the previously observed PC is 0.
- R2: When pcValid is high, freeze is low and pcIn differs from the previously observed PC plus 4, pcIn is written at the write pointer on that clock edge. From the next cycle it reads back at index 31, the newest entry.
- R3: A valid PC equal to the previously observed PC plus 4 writes nothing and does not move the pointer, so every read index returns what it returned before.
- R4: Each write advances the pointer by one modulo 32. After more than 32 captures only the last 32 remain, oldest at index 0 and newest at index 31.
- R5: The previously observed PC takes the value of pcIn on every valid cycle, whether or not an entry was written. Because it resets to 0, a first PC of 4 after reset is not captured.
- R6: While pcValid is low, pcIn is ignored: nothing is written and the previously observed PC is unchanged.
- R7: While freeze is high, nothing is written and the pointer holds. The previously observed PC still tracks valid PCs.
- R8: rdData returns the entry at (write pointer + rdIdx) mod 32 combinationally. A read made in the same cycle as a capture returns the contents before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pcValid | input | 1 | The PC on pcIn is valid this cycle |
| pcIn | input | 32 | Observed program counter |
| freeze | input | 1 | Suspends capture while high |
| rdIdx | input | 5 | Logical read index, 0 = oldest |
| rdData | output | 32 | History entry at the logical index |

## Verification
The bench targets the first PC after reset. A design that seeded the previous PC with anything but 0 would capture address 4 or miss address 0. It also runs long sequential runs, idle cycles holding a stray pcIn and freeze windows, in which a design that skipped the previous-PC update would record a false target once capture resumes. A run of 40 captures checks the ordering after the history wraps: an off-by-one read origin shows up as a rotated history. A read held at index 0 during a capture edge catches a read path that forwards the new value instead of the stored one.

// File: rtl/branch_trace_pkg.sv
`timescale 1ns/1ps
package branch_trace_pkg;
  // Strobes sent from control to the storage datapath
  typedef struct packed {
    logic capture;   // write pcIn at the write pointer this edge
  } traceStrobes_t;
endpackage

// File: rtl/branch_trace_ctrl.sv
`timescale 1ns/1ps
module branch_trace_ctrl
  import branch_trace_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int DEPTH   = 32,
  parameter int PC_STEP = 4,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pcValid,
  input  logic [WIDTH-1:0] pcIn,
  input  logic             freeze,
  output traceStrobes_t    strb,
  output logic [IDX_W-1:0] wrPtr
);
  logic [WIDTH-1:0] prevPc;
  logic [WIDTH-1:0] seqPc;
  logic             isJump;

  assign seqPc        = prevPc + WIDTH'(PC_STEP);
  assign isJump       = (pcIn != seqPc);
  assign strb.capture = pcValid && !freeze && isJump;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevPc <= '0;
      wrPtr  <= '0;
    end else begin
      if (pcValid) prevPc <= pcIn;
      if (strb.capture) wrPtr <= wrPtr + 1'b1;
    end
  end

  assert_prev_tracks_R5: assert property (@(posedge clk) disable iff (!rstN)
    pcValid |=> prevPc == $past(pcIn));
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !pcValid |=> $stable(prevPc) && $stable(wrPtr));
  assert_freeze_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    freeze |=> $stable(wrPtr));
  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> wrPtr == IDX_W'($past(wrPtr) + 1'b1));
  assert_seq_skip_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pcValid && pcIn == prevPc + WIDTH'(PC_STEP)) |=> $stable(wrPtr));
endmodule

// File: rtl/branch_trace_store.sv
`timescale 1ns/1ps
module branch_trace_store
  import branch_trace_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int DEPTH  = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  traceStrobes_t    strb,
  input  logic [IDX_W-1:0] wrPtr,
  input  logic [WIDTH-1:0] wrData,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [WIDTH-1:0] rdData
);
  logic [WIDTH-1:0] entries [DEPTH];
  logic [IDX_W-1:0] rdPtr;

  for (genvar e = 0; e < DEPTH; e++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) entries[e] <= '1;
      else if (strb.capture && wrPtr == IDX_W'(e)) entries[e] <= wrData;
    end
  end

  // Depth is a power of two, so the index wraps by truncation
  assign rdPtr  = wrPtr + rdIdx;
  assign rdData = entries[rdPtr];

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> entries[$past(wrPtr)] == $past(wrData));
  assert_no_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.capture && $stable(wrPtr)) |=> $stable(rdData) || !$stable(rdIdx));
endmodule

// File: rtl/branch_trace_buf.sv
`timescale 1ns/1ps
module branch_trace_buf
  import branch_trace_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int DEPTH   = 32,
  parameter int PC_STEP = 4,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pcValid,
  input  logic [WIDTH-1:0] pcIn,
  input  logic             freeze,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [WIDTH-1:0] rdData
);
  traceStrobes_t    strb;
  logic [IDX_W-1:0] wrPtr;

  branch_trace_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH), .PC_STEP(PC_STEP)) uCtrl (
    .clk(clk), .rstN(rstN), .pcValid(pcValid), .pcIn(pcIn),
    .freeze(freeze), .strb(strb), .wrPtr(wrPtr)
  );

  branch_trace_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uStore (
    .clk(clk), .rstN(rstN), .strb(strb), .wrPtr(wrPtr),
    .wrData(pcIn), .rdIdx(rdIdx), .rdData(rdData)
  );
endmodule

// File: tb/sim_branch_trace_buf.sv
`timescale 1ns/1ps
module sim_branch_trace_buf;
  logic        clk = 0;
  logic        rstN = 0;
  logic        pcValid = 0;
  logic [31:0] pcIn = '0;
  logic        freeze = 0;
  logic [4:0]  rdIdx = '0;
  logic [31:0] rdData;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [31:0] mHist [32];
  int          mPtr;
  logic [31:0] mPrev;

  branch_trace_buf u0 (.clk(clk), .rstN(rstN), .pcValid(pcValid), .pcIn(pcIn),
                       .freeze(freeze), .rdIdx(rdIdx), .rdData(rdData));

  always #2 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic readAt(int idx, output logic [31:0] v);
    rdIdx = 5'(idx);
    #0.1;
    v = rdData;
  endtask

  task automatic compareAll(string req);
    logic [31:0] v;
    @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      readAt(i, v);
      check(req, v, mHist[(mPtr + i) % 32]);
    end
  endtask

  task automatic pushPc(logic [31:0] pc);
    @(negedge clk);
    pcValid = 1; pcIn = pc;
    @(negedge clk);
    pcValid = 0;
    if (!freeze && pc != mPrev + 32'd4) begin
      mHist[mPtr] = pc;
      mPtr = (mPtr + 1) % 32;
    end
    mPrev = pc;
  endtask

  task automatic t_reset;  // R1
    for (int i = 0; i < 32; i++) mHist[i] = 32'hFFFF_FFFF;
    mPtr = 0; mPrev = 0;
    compareAll("R1 reset contents");
  endtask

  task automatic t_first;  // R5, R2
    logic [31:0] v;
    pushPc(32'h4);
    compareAll("R5 first pc 4 not captured");
    pushPc(32'h100);
    readAt(31, v);
    check("R2 newest at index 31", v, 32'h100);
  endtask

  task automatic t_seq;  // R3
    pushPc(32'h104);
    pushPc(32'h108);
    compareAll("R3 sequential ignored");
  endtask

  task automatic t_invalid;  // R6
    @(negedge clk);
    pcIn = 32'h500;
    repeat (3) @(negedge clk);
    pushPc(32'h10C);
    compareAll("R6 invalid pc ignored");
  endtask

  task automatic t_freeze;  // R7
    logic [31:0] v;
    freeze = 1;
    pushPc(32'h2000);
    compareAll("R7 frozen no capture");
    freeze = 0;
    pushPc(32'h2004);
    compareAll("R7 prev tracked while frozen");
    pushPc(32'h3000);
    readAt(31, v);
    check("R7 capture resumes", v, 32'h3000);
  endtask

  task automatic t_wrap;  // R4
    for (int k = 0; k < 40; k++) pushPc(32'h8000_0000 + 32'(k) * 32'h40);
    compareAll("R4 wrap order");
  endtask

  task automatic t_same;  // R8
    logic [31:0] v;
    logic [31:0] oldest;
    oldest = mHist[mPtr];
    @(negedge clk);
    rdIdx = 0; pcValid = 1; pcIn = 32'hC0DE_0000;
    #1;
    v = rdData;
    check("R8 same-cycle read sees old", v, oldest);
    @(negedge clk);
    pcValid = 0;
    mHist[mPtr] = 32'hC0DE_0000; mPtr = (mPtr + 1) % 32; mPrev = 32'hC0DE_0000;
    readAt(31, v);
    check("R8 new value after edge", v, 32'hC0DE_0000);
    compareAll("R8 history after capture");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset();
    t_first();
    t_seq();
    t_invalid();
    t_freeze();
    t_wrap();
    t_same();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule